// File: doc/BRIEF.md
# Serial Character Transmitter with Ninth and Tenth Data Bits

This block turns parallel characters into an asynchronous serial stream on one output line. A character carries eight, nine or ten data bits. Two mode inputs pick the length. The low eight bits are held in a byte register. The two upper bits are held in a separate pair of staged control bits. Both together form a one-character holding buffer that sits in front of a shift register.

Software can update the upper bits in two ways. It can write the staged pair on its own and then do a byte write of the low eight bits. Or it can do one wide write that places all ten bits in a single cycle. The staged upper bits are not cleared when a character goes out, so a run of characters that share their upper bits needs only byte writes. When the shifter is free, it takes the low byte and the staged upper bits together in one clock. Each serial bit lasts from one pulse of the external baud strobe to the next. Upper bits are sent as ordinary data; they are never parity.

Top module: `ext_char_uart_tx`

## Requirements
- R1: The character length is 8 data bits when both mode inputs are low, 9 when only `mode9_i` is high, and 10 when `mode10_i` is high, whatever the value of `mode9_i`.
- R2: A frame is a single low start bit, then the data bits least significant first, then a single high stop bit. The line rests high out of reset and between frames.
- R3: A byte write (`dat_wr_i` high, `dat_wide_i` low) replaces only data bits 7:0. The character then carries the staged upper bits as its bits 8 and 9.
- R4: A control write (`ctl_wr_i`) sets the staged upper bits, with `ctl_hi_i[0]` as bit 8 and `ctl_hi_i[1]` as bit 9. A wide write (`dat_wr_i` and `dat_wide_i` high) loads all ten bits of `dat_i` in the same cycle, and its bits 9:8 become the new staged upper bits.
- R5: The staged upper bits keep their value after a character is sent. Later byte writes reuse them until they are written again.
- R6: When the buffer passes to the shifter, bits 7:0 and the staged upper bits are captured in the same cycle. A control write made after that cycle does not change the character in flight.
- R7: The line level changes only in the cycle after a baud strobe or after a character is loaded. Each data, start and stop bit ends on a baud strobe.
- R8: `buf_empty_o` is high out of reset. It falls in the cycle after any data write and rises in the cycle after the buffer passes to the shifter.
- R9: `tx_complete_o` is high exactly when the shifter is idle and the buffer is empty, which includes the state out of reset.
- R10: If a character is waiting in the buffer when a stop bit ends, its start bit follows at once with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle strobe that ends each serial bit |
| mode9_i | input | 1 | Selects 9 data bits |
| mode10_i | input | 1 | Selects 10 data bits; overrides `mode9_i` |
| ctl_wr_i | input | 1 | Write strobe for the staged upper bits |
| ctl_hi_i | input | 2 | New staged bits 9:8 |
| dat_wr_i | input | 1 | Write strobe for the data register |
| dat_wide_i | input | 1 | With `dat_wr_i`: high loads all ten bits, low loads only bits 7:0 |
| dat_i | input | 10 | Write data |
| txd_o | output | 1 | Serial line output |
| buf_empty_o | output | 1 | Holding buffer has been taken by the shifter |
| tx_complete_o | output | 1 | Nothing buffered and nothing shifting |

## Verification
The cycle-level rules are checked by properties on every cycle. These cover the flag edges after writes and loads, and the staged upper bits holding when nothing writes them. They also cover the low byte holding when no data write occurs, and the line moving only after a strobe or a load. They further check that a load starts with a low bit, that the last bit before the end of a frame is high, and that the line is high whenever the block reports completion. The bench is needed for the rest. It decodes frames at the actual length for each mode setting, which shows mode priority. It tracks the staged bits across chains of byte, control and wide writes, and shows that a control write made while a character is shifting does not alter that character. It also confirms that a buffered character starts right after the stop bit.

// File: rtl/wct_pkg.sv
`timescale 1ns/1ps
package wct_pkg;
    localparam int unsigned LOW_W   = 8;
    localparam int unsigned HI_W    = 2;
    localparam int unsigned DATA_W  = LOW_W + HI_W;
    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        CHAR_8  = 2'd0,
        CHAR_9  = 2'd1,
        CHAR_10 = 2'd2
    } char_len_e;

    // the ten-bit setting wins over the nine-bit one
    function automatic char_len_e pick_len(input logic sel9, input logic sel10);
        if (sel10)     return CHAR_10;
        else if (sel9) return CHAR_9;
        else           return CHAR_8;
    endfunction

    function automatic logic [CNT_W-1:0] len_bits(input char_len_e len);
        case (len)
            CHAR_10: return CNT_W'(DATA_W);
            CHAR_9:  return CNT_W'(LOW_W + 1);
            default: return CNT_W'(LOW_W);
        endcase
    endfunction

    // start bit at position 0, data next, every slot past the data is a stop level
    function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] data,
                                                       input char_len_e len);
        logic [FRAME_W-1:0] f;
        logic [CNT_W-1:0]   n;
        n = len_bits(len);
        f = {1'b1, data, 1'b0};
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) >= n) f[i+1] = 1'b1;
        end
        return f;
    endfunction
endpackage

// File: rtl/wct_stage.sv
`timescale 1ns/1ps
module wct_stage
    import wct_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctl_wr_i,
    input  logic [HI_W-1:0]   ctl_hi_i,
    input  logic              dat_wr_i,
    input  logic              dat_wide_i,
    input  logic [DATA_W-1:0] dat_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] buf_data_o,
    output logic              buf_empty_o
);
    typedef struct packed {
        logic [LOW_W-1:0] low;
        logic [HI_W-1:0]  hi;
        logic             empty;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i)   st_d.empty = 1'b1;
        if (ctl_wr_i) st_d.hi    = ctl_hi_i;
        if (dat_wr_i) begin
            st_d.low   = dat_i[LOW_W-1:0];
            st_d.empty = 1'b0;
            if (dat_wide_i) st_d.hi = dat_i[DATA_W-1:LOW_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{low: '0, hi: '0, empty: 1'b1};
        else         st_q <= st_d;
    end

    assign buf_data_o  = {st_q.hi, st_q.low};
    assign buf_empty_o = st_q.empty;

    p_empty_falls_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dat_wr_i |=> !buf_empty_o);
    p_empty_rises_on_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !dat_wr_i) |=> buf_empty_o);
    p_upper_bits_persist_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctl_wr_i && !(dat_wr_i && dat_wide_i)) |=> $stable(buf_data_o[DATA_W-1:LOW_W]));
    p_low_byte_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dat_wr_i |=> $stable(buf_data_o[LOW_W-1:0]));
endmodule

// File: rtl/wct_shifter.sv
`timescale 1ns/1ps
module wct_shifter
    import wct_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              baud_tick_i,
    input  logic              mode9_i,
    input  logic              mode10_i,
    input  logic              have_data_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              take_o,
    output logic              txd_o,
    output logic              busy_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
        logic               busy;
    } shift_t;

    shift_t    sh_d, sh_q;
    char_len_e len_sel;
    logic      last_bit;
    logic      take;

    always_comb begin
        len_sel  = pick_len(mode9_i, mode10_i);
        last_bit = sh_q.busy && baud_tick_i && (sh_q.left == CNT_W'(1));
        take     = have_data_i && (!sh_q.busy || last_bit);
        sh_d     = sh_q;
        if (take) begin
            sh_d.frame = build_frame(data_i, len_sel);
            sh_d.left  = len_bits(len_sel) + CNT_W'(2);
            sh_d.busy  = 1'b1;
        end else if (sh_q.busy && baud_tick_i) begin
            sh_d.frame = {1'b1, sh_q.frame[FRAME_W-1:1]};
            sh_d.left  = sh_q.left - CNT_W'(1);
            if (last_bit) sh_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '{frame: '1, left: '0, busy: 1'b0};
        else         sh_q <= sh_d;
    end

    assign take_o = take;
    assign busy_o = sh_q.busy;
    assign txd_o  = sh_q.busy ? sh_q.frame[0] : 1'b1;

    p_start_low_after_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |=> !txd_o);
    p_stop_level_at_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_bit |-> txd_o);
    p_line_moves_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(txd_o) |-> ($past(baud_tick_i) || $past(take_o)));
endmodule

// File: rtl/ext_char_uart_tx.sv
`timescale 1ns/1ps
module ext_char_uart_tx
    import wct_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              baud_tick_i,
    input  logic              mode9_i,
    input  logic              mode10_i,
    input  logic              ctl_wr_i,
    input  logic [HI_W-1:0]   ctl_hi_i,
    input  logic              dat_wr_i,
    input  logic              dat_wide_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic              txd_o,
    output logic              buf_empty_o,
    output logic              tx_complete_o
);
    logic [DATA_W-1:0] buf_data;
    logic              buf_empty;
    logic              take;
    logic              busy;

    wct_stage u_stage (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctl_wr_i    (ctl_wr_i),
        .ctl_hi_i    (ctl_hi_i),
        .dat_wr_i    (dat_wr_i),
        .dat_wide_i  (dat_wide_i),
        .dat_i       (dat_i),
        .take_i      (take),
        .buf_data_o  (buf_data),
        .buf_empty_o (buf_empty)
    );

    wct_shifter u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .baud_tick_i (baud_tick_i),
        .mode9_i     (mode9_i),
        .mode10_i    (mode10_i),
        .have_data_i (!buf_empty),
        .data_i      (buf_data),
        .take_o      (take),
        .txd_o       (txd_o),
        .busy_o      (busy)
    );

    assign buf_empty_o   = buf_empty;
    assign tx_complete_o = buf_empty && !busy;

    p_complete_line_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_complete_o |-> txd_o);
endmodule

// File: tb/ext_char_uart_tx_tb_top.sv
`timescale 1ns/1ps
module ext_char_uart_tx_tb_top;
    localparam int DIV  = 4;
    localparam int SEED = 1337;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, m9 = 1'b0, m10 = 1'b0;
    logic       ctl_wr = 1'b0, dat_wr = 1'b0, dat_wide = 1'b0;
    logic [1:0] ctl_hi = '0;
    logic [9:0] dat = '0;
    logic       txd, empty, done;

    always #2 clk = ~clk;

    ext_char_uart_tx dut_i (
        .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .mode9_i(m9), .mode10_i(m10),
        .ctl_wr_i(ctl_wr), .ctl_hi_i(ctl_hi), .dat_wr_i(dat_wr), .dat_wide_i(dat_wide),
        .dat_i(dat), .txd_o(txd), .buf_empty_o(empty), .tx_complete_o(done)
    );

    int         total = 0, bad = 0;
    logic [1:0] stage_m = 2'b00;
    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [9:0] rx_q[$];
    int         gap_q[$];
    int         cmp_idx = 0;
    int         rx_st = 0, bitpos = 0, rx_len = 8, idle_cnt = 1000, phase = 0;
    int         r7_viol = 0, stop_err = 0;
    logic [9:0] acc = '0;
    bit         in_frame = 1'b0;
    logic       last_txd = 1'b1;

    function automatic int width_of(input logic a9, input logic a10);
        return a10 ? 10 : (a9 ? 9 : 8);
    endfunction

    function automatic logic [9:0] mask_to(input logic [9:0] v, input int n);
        return v & 10'((1 << n) - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // baud strobe generator and reference line decoder
    always @(negedge clk) begin
        if (!rst_n) begin
            tick = 1'b0; phase = 0;
        end else begin
            if (in_frame && !tick && txd !== last_txd) r7_viol++;
            last_txd = txd;
            if (phase == DIV - 1) begin
                phase = 0;
                tick  = 1'b1;
                case (rx_st)
                    0: if (txd == 1'b0) begin
                           rx_st = 1; bitpos = 0; acc = '0; in_frame = 1'b1;
                           rx_len = width_of(m9, m10);
                           gap_q.push_back(idle_cnt);
                       end else idle_cnt++;
                    1: begin
                           acc[bitpos] = txd;
                           bitpos++;
                           if (bitpos == rx_len) rx_st = 2;
                       end
                    default: begin
                           if (txd != 1'b1) stop_err++;
                           rx_q.push_back(acc);
                           rx_st = 0; idle_cnt = 0; in_frame = 1'b0;
                       end
                endcase
            end else begin
                phase++;
                tick = 1'b0;
            end
        end
    end

    task automatic wr_ctl(input logic [1:0] h);
        ctl_wr = 1'b1; ctl_hi = h;
        @(negedge clk);
        ctl_wr = 1'b0;
        stage_m = h;
    endtask

    task automatic wr_byte(input logic [7:0] b, input string tag);
        dat_wr = 1'b1; dat_wide = 1'b0; dat = {2'b00, b};
        @(negedge clk);
        dat_wr = 1'b0;
        exp_q.push_back(mask_to({stage_m, b}, width_of(m9, m10)));
        tag_q.push_back(tag);
    endtask

    task automatic wr_wide(input logic [9:0] v, input string tag);
        dat_wr = 1'b1; dat_wide = 1'b1; dat = v;
        @(negedge clk);
        dat_wr = 1'b0; dat_wide = 1'b0;
        stage_m = v[9:8];
        exp_q.push_back(mask_to(v, width_of(m9, m10)));
        tag_q.push_back(tag);
    endtask

    task automatic wait_empty();
        while (!empty) @(negedge clk);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
        repeat (DIV + 2) @(negedge clk);
    endtask

    task automatic compare_all();
        wait_done();
        for (int k = cmp_idx; k < exp_q.size(); k++) begin
            if (k < rx_q.size())
                check(rx_q[k] == exp_q[k], tag_q[k], "received character", rx_q[k], exp_q[k]);
            else
                check(1'b0, tag_q[k], "character missing", 0, exp_q[k]);
        end
        cmp_idx = exp_q.size();
        check(rx_q.size() == exp_q.size(), "R2", "frame count", rx_q.size(), exp_q.size());
    endtask

    initial begin
        int gap_idx;
        void'($urandom(SEED));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R2", "idle line after reset", txd, 1);
        check(empty == 1'b1, "R8", "empty after reset", empty, 1);
        check(done == 1'b1, "R9", "complete after reset", done, 1);

        // flag sequence on a single 8-bit character
        wr_byte(8'hA5, "R2");
        check(empty == 1'b0, "R8", "empty after write", empty, 0);
        check(done == 1'b0, "R9", "complete with buffer full", done, 0);
        @(negedge clk);
        check(empty == 1'b1, "R8", "empty after load", empty, 1);
        check(done == 1'b0, "R9", "complete while shifting", done, 0);
        wait_done();
        check(done == 1'b1 && txd == 1'b1, "R9", "complete and idle at end", {done, txd}, 3);
        compare_all();

        // length selection, including the case with both controls set
        for (int c = 0; c < 4; c++) begin
            m9 = c[0]; m10 = c[1];
            @(negedge clk);
            wr_wide(10'h3A6, (c == 3) ? "R1 priority" : "R1");
            compare_all();
        end

        // staged upper bits with byte writes in 10-bit mode
        m9 = 1'b0; m10 = 1'b1;
        @(negedge clk);
        wr_ctl(2'b10);
        wr_byte(8'h3C, "R3");
        wait_empty();
        wr_byte(8'hC3, "R5");
        wait_empty();
        wr_wide(10'h1FF, "R4");
        wait_empty();
        wr_byte(8'h00, "R5");
        compare_all();

        // capture instant and back-to-back start
        wr_ctl(2'b01);
        wr_byte(8'h55, "R6");
        wait_empty();
        wr_ctl(2'b10);
        gap_idx = exp_q.size();
        wr_byte(8'hAA, "R6");
        compare_all();
        if (gap_idx < gap_q.size())
            check(gap_q[gap_idx] == 0, "R10", "idle bits between frames", gap_q[gap_idx], 0);
        else
            check(1'b0, "R10", "second frame missing", 0, 0);

        // random mix of write kinds and lengths
        for (int i = 0; i < 48; i++) begin
            int op;
            if (i % 8 == 0) begin
                compare_all();
                m9 = 1'($urandom % 2); m10 = 1'($urandom % 2);
                @(negedge clk);
            end
            op = $urandom % 3;
            wait_empty();
            if (op == 0) begin
                wr_ctl(2'($urandom % 4));
                wr_byte(8'($urandom), "R4");
            end else if (op == 1) begin
                wr_byte(8'($urandom), "R3");
            end else begin
                wr_wide(10'($urandom), "R4");
            end
        end
        compare_all();

        check(stop_err == 0, "R2", "bad stop bits", stop_err, 0);
        check(r7_viol == 0, "R7", "line changes between strobes", r7_viol, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule